// File: doc/BRIEF.md
# Floating-point control and status register

This block holds the 32-bit control/status word of a floating-point unit. It has two ports. Software uses the control port to read and write the word by index. The arithmetic pipeline uses the update port to report, once per completed operation, which of five exceptions that operation raised.

The word carries:
- the rounding mode;
- a flush control bit;
- five trap enables;
- five sticky flags that accumulate over time;
- five cause bits that describe only the most recent operation;
- eight condition-code bits, each addressable with a 3-bit selector.

When a caused exception meets its enable, the block raises a one-cycle trap. In the same cycle it withholds the write-back of the pending result and any condition-code update. A software write that enables an exception whose cause bit is already set raises the trap at once. Computing the exceptions is left to the arithmetic units.

All outputs are registered. A change made at a clock edge shows on `trap`, `wb_en`, `round_mode` and `flush_en` right after that edge. The read data and the condition-code bit are one more register stage behind, because they sample the stored word.

Top module: `fpu_csr_unit`

## Requirements
- R1: Synchronous reset clears the whole word. `sw_rdata`, `cc_rd_bit`, `trap`, `wb_en`, `round_mode` and `flush_en` all read zero after reset.
- R2: Writes by software update only these bits of the word:
  - flush (bit 24);
  - enables (bits 11:7);
  - flags (bits 6:2);
  - rounding mode (bits 1:0).
  Every other bit keeps its value. A write to any index other than 31 changes nothing.
- R3: A read at index 31 returns the word as it was in the cycle of the request. Index 0 and every other index return zero.
- R4: Each operation replaces the cause field (bits 16:12) with its exception vector. Within each 5-bit group the order from LSB upward is inexact, underflow, overflow, divide-by-zero, invalid.
- R5: Each operation ORs its exception vector into the flags (bits 6:2). Flags are never cleared except by a software write.
- R6: An operation whose exceptions meet an enable (cause bit n+12 with enable bit n+7) gives `trap` high for one cycle after the edge.
- R7: `wb_en` follows a write-back request of an operation, one cycle later. It stays low when that operation traps.
- R8: A software write that leaves a set cause bit aligned with a set enable bit raises `trap`. A write that does not do so raises no trap.
- R9: An operation may write condition code n to bit 23 (n = 0) or bit 24+n (n = 1..7). The write is suppressed when a trap is raised in that cycle.
- R10: `cc_rd_bit` returns the condition code selected by `cc_rd_sel`, using the same bit mapping as R9.
- R11: `round_mode` shows bits 1:0 and `flush_en` shows bit 24 of the stored word.
- R12: A software write and an operation in the same cycle both take effect:
  - the flags end up as the written flags ORed with the new exceptions;
  - the cause field comes from the operation;
  - the trap test uses the combined word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_idx | input | IDX_W | Software write register index |
| sw_wdata | input | 32 | Software write data |
| sw_rd_idx | input | IDX_W | Software read register index |
| sw_rdata | output | 32 | Registered read data |
| op_valid | input | 1 | An arithmetic operation completes this cycle |
| op_exc | input | 5 | Exceptions of that operation |
| op_wb_req | input | 1 | The operation has a result to write back |
| op_cc_wr | input | 1 | The operation writes a condition code |
| op_cc_sel | input | 3 | Condition code to write |
| op_cc_val | input | 1 | Condition code value |
| cc_rd_sel | input | 3 | Condition code to read |
| cc_rd_bit | output | 1 | Registered selected condition code |
| round_mode | output | 2 | Current rounding mode |
| flush_en | output | 1 | Current flush control |
| trap | output | 1 | One-cycle trap pulse |
| wb_en | output | 1 | Result write-back permission |

## Verification
Two functions can fall in the same cycle: a software write to index 31 and an operation completing.

The bench provokes this by driving both in one cycle. In one case the write enables the invalid exception that the operation raises. In another case the write seeds a flag while the operation adds a different one.

It judges the outcome by reading the word back afterwards and comparing it with a model built from the requirements. It also checks the trap pulse and the withheld write-back in the cycle after the collision.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int CSR_W     = 32;
  localparam int EXC_N     = 5;
  localparam int CC_N      = 8;
  localparam int CC_SEL_W  = $clog2(CC_N);
  localparam int RM_W      = 2;
  localparam int RM_LSB    = 0;
  localparam int FLAG_LSB  = 2;
  localparam int EN_LSB    = 7;
  localparam int CAUSE_LSB = 12;
  localparam int CC0_POS   = 23;
  localparam int FLUSH_POS = 24;
  localparam int CCHI_LSB  = 25;

  // bit position of condition code n
  function automatic int cc_bit_pos(input int n);
    return (n == 0) ? CC0_POS : (CCHI_LSB + n - 1);
  endfunction

  // bits that software may change
  function automatic logic [CSR_W-1:0] sw_mask();
    logic [CSR_W-1:0] m;
    m = '0;
    for (int i = 0; i < RM_W; i++)  m[RM_LSB + i]   = 1'b1;
    for (int i = 0; i < EXC_N; i++) m[FLAG_LSB + i] = 1'b1;
    for (int i = 0; i < EXC_N; i++) m[EN_LSB + i]   = 1'b1;
    m[FLUSH_POS] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fpcsr_trap_chk.sv
module fpcsr_trap_chk #(
  parameter int N = 5
) (
  input  logic [N-1:0] cause_i,
  input  logic [N-1:0] en_i,
  output logic         hit_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_match
    assign match[g] = cause_i[g] & en_i[g];
  end

  assign hit_o = |match;
endmodule

// File: rtl/fpcsr_next.sv
module fpcsr_next
  import fpcsr_pkg::*;
(
  input  logic [CSR_W-1:0]    csr_i,
  input  logic                wr_hit_i,
  input  logic [CSR_W-1:0]    wdata_i,
  input  logic                op_valid_i,
  input  logic [EXC_N-1:0]    exc_i,
  input  logic                cc_wr_i,
  input  logic [CC_SEL_W-1:0] cc_sel_i,
  input  logic                cc_val_i,
  output logic [CSR_W-1:0]    csr_o,
  output logic                trap_o
);
  localparam logic [CSR_W-1:0] WMASK = sw_mask();

  logic [CSR_W-1:0] merged;
  logic             hit;

  // software write first, then the operation's cause and sticky update
  always_comb begin
    merged = csr_i;
    if (wr_hit_i) merged = (csr_i & ~WMASK) | (wdata_i & WMASK);
    if (op_valid_i) begin
      merged[CAUSE_LSB +: EXC_N] = exc_i;
      merged[FLAG_LSB +: EXC_N]  = merged[FLAG_LSB +: EXC_N] | exc_i;
    end
  end

  fpcsr_trap_chk #(.N(EXC_N)) trap_chk_i (
    .cause_i (merged[CAUSE_LSB +: EXC_N]),
    .en_i    (merged[EN_LSB +: EXC_N]),
    .hit_o   (hit)
  );

  assign trap_o = (wr_hit_i | op_valid_i) & hit;

  // condition code write, withheld on trap
  always_comb begin
    csr_o = merged;
    if (op_valid_i && cc_wr_i && !trap_o) begin
      for (int n = 0; n < CC_N; n++) begin
        if (cc_sel_i == CC_SEL_W'(n)) csr_o[cc_bit_pos(n)] = cc_val_i;
      end
    end
  end
endmodule

// File: rtl/fpcsr_rdport.sv
module fpcsr_rdport
  import fpcsr_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int CSR_IDX = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CSR_W-1:0]    csr_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  input  logic [CC_SEL_W-1:0] cc_sel_i,
  output logic [CSR_W-1:0]    rdata_o,
  output logic                cc_bit_o
);
  logic cc_pick;

  always_comb begin
    cc_pick = 1'b0;
    for (int n = 0; n < CC_N; n++) begin
      if (cc_sel_i == CC_SEL_W'(n)) cc_pick = csr_i[cc_bit_pos(n)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      cc_bit_o <= 1'b0;
    end else begin
      rdata_o  <= (rd_idx_i == IDX_W'(CSR_IDX)) ? csr_i : '0;
      cc_bit_o <= cc_pick;
    end
  end

  // R3: indices other than the status word read as zero
  assert_other_idx_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_idx_i != IDX_W'(CSR_IDX)) |=> (rdata_o == '0));
endmodule

// File: rtl/fpu_csr_unit.sv
module fpu_csr_unit
  import fpcsr_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int CSR_IDX = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sw_wr_en,
  input  logic [IDX_W-1:0]    sw_idx,
  input  logic [CSR_W-1:0]    sw_wdata,
  input  logic [IDX_W-1:0]    sw_rd_idx,
  output logic [CSR_W-1:0]    sw_rdata,
  input  logic                op_valid,
  input  logic [EXC_N-1:0]    op_exc,
  input  logic                op_wb_req,
  input  logic                op_cc_wr,
  input  logic [CC_SEL_W-1:0] op_cc_sel,
  input  logic                op_cc_val,
  input  logic [CC_SEL_W-1:0] cc_rd_sel,
  output logic                cc_rd_bit,
  output logic [RM_W-1:0]     round_mode,
  output logic                flush_en,
  output logic                trap,
  output logic                wb_en
);
  logic [CSR_W-1:0] csr_q, csr_d;
  logic             wr_hit, trap_evt, trap_q, wb_q;

  assign wr_hit = sw_wr_en && (sw_idx == IDX_W'(CSR_IDX));

  fpcsr_next next_i (
    .csr_i      (csr_q),
    .wr_hit_i   (wr_hit),
    .wdata_i    (sw_wdata),
    .op_valid_i (op_valid),
    .exc_i      (op_exc),
    .cc_wr_i    (op_cc_wr),
    .cc_sel_i   (op_cc_sel),
    .cc_val_i   (op_cc_val),
    .csr_o      (csr_d),
    .trap_o     (trap_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_q  <= '0;
      trap_q <= 1'b0;
      wb_q   <= 1'b0;
    end else begin
      csr_q  <= csr_d;
      trap_q <= trap_evt;
      wb_q   <= op_valid && op_wb_req && !trap_evt;
    end
  end

  fpcsr_rdport #(.IDX_W(IDX_W), .CSR_IDX(CSR_IDX)) rdport_i (
    .clk      (clk),
    .rst      (rst),
    .csr_i    (csr_q),
    .rd_idx_i (sw_rd_idx),
    .cc_sel_i (cc_rd_sel),
    .rdata_o  (sw_rdata),
    .cc_bit_o (cc_rd_bit)
  );

  assign round_mode = csr_q[RM_LSB +: RM_W];
  assign flush_en   = csr_q[FLUSH_POS];
  assign trap       = trap_q;
  assign wb_en      = wb_q;

  // R1: state is clear on leaving reset
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (csr_q == '0 && !trap_q && !wb_q));

  // R2: software cannot touch the cause field
  assert_cause_sw_locked_R2: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(csr_q[CAUSE_LSB +: EXC_N]));

  // R4: cause takes the operation's exception set
  assert_cause_load_R4: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (csr_q[CAUSE_LSB +: EXC_N] == $past(op_exc)));

  // R5: flags only grow without a software write
  assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> ((csr_q[FLAG_LSB +: EXC_N] & $past(csr_q[FLAG_LSB +: EXC_N]))
                 == $past(csr_q[FLAG_LSB +: EXC_N])));

  // R6: a trap needs an enabled cause
  assert_trap_cause_R6: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> |(csr_q[CAUSE_LSB +: EXC_N] & csr_q[EN_LSB +: EXC_N]));

  // R7: write-back withheld on trap
  assert_wb_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> !wb_q);

  // R9: condition codes untouched on trap
  assert_cc_hold_R9: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> ({csr_q[CSR_W-1:CCHI_LSB], csr_q[CC0_POS]} ==
                $past({csr_q[CSR_W-1:CCHI_LSB], csr_q[CC0_POS]})));
endmodule

// File: tb/fpu_csr_unit_tb_top.sv
module fpu_csr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_wr_en = 1'b0;
  logic [4:0]  sw_idx = '0;
  logic [31:0] sw_wdata = '0;
  logic [4:0]  sw_rd_idx = '0;
  logic [31:0] sw_rdata;
  logic        op_valid = 1'b0;
  logic [4:0]  op_exc = '0;
  logic        op_wb_req = 1'b0;
  logic        op_cc_wr = 1'b0;
  logic [2:0]  op_cc_sel = '0;
  logic        op_cc_val = 1'b0;
  logic [2:0]  cc_rd_sel = '0;
  logic        cc_rd_bit;
  logic [1:0]  round_mode;
  logic        flush_en;
  logic        trap;
  logic        wb_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_csr_unit dut_i (
    .clk(clk), .rst(rst), .sw_wr_en(sw_wr_en), .sw_idx(sw_idx),
    .sw_wdata(sw_wdata), .sw_rd_idx(sw_rd_idx), .sw_rdata(sw_rdata),
    .op_valid(op_valid), .op_exc(op_exc), .op_wb_req(op_wb_req),
    .op_cc_wr(op_cc_wr), .op_cc_sel(op_cc_sel), .op_cc_val(op_cc_val),
    .cc_rd_sel(cc_rd_sel), .cc_rd_bit(cc_rd_bit), .round_mode(round_mode),
    .flush_en(flush_en), .trap(trap), .wb_en(wb_en)
  );

  typedef struct {
    logic        trap;
    logic        wb;
    logic [31:0] rdata;
    logic        ccb;
    logic [1:0]  rm;
    logic        fl;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  exp_t        cur;
  logic [31:0] mdl = '0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  // Condition-code position per R9: code 0 at bit 23, code n at bit 24+n
  function automatic int ccpos(input logic [2:0] n);
    return (n == 3'd0) ? 23 : 24 + int'(n);
  endfunction

  // Build a software word: flush bit 24, enables 11:7, flags 6:2, mode 1:0
  function automatic logic [31:0] mk(input logic fl, input logic [4:0] en,
                                     input logic [4:0] flg, input logic [1:0] rm);
    return (32'(fl) << 24) | (32'(en) << 7) | (32'(flg) << 2) | 32'(rm);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic cyc(input string tag, input logic r, input logic we,
                     input logic [4:0] widx, input logic [31:0] wd,
                     input logic ov, input logic [4:0] ex, input logic wbr,
                     input logic cw, input logic [2:0] cs, input logic cv,
                     input logic [4:0] ri, input logic [2:0] crs);
    exp_t        e;
    logic [31:0] nxt;
    logic        hit, tr;
    @(negedge clk);
    rst = r; sw_wr_en = we; sw_idx = widx; sw_wdata = wd;
    op_valid = ov; op_exc = ex; op_wb_req = wbr;
    op_cc_wr = cw; op_cc_sel = cs; op_cc_val = cv;
    sw_rd_idx = ri; cc_rd_sel = crs;
    e.tag = tag;
    if (r) begin
      mdl = '0;
      e.trap = 0; e.wb = 0; e.rdata = '0; e.ccb = 0;
    end else begin
      e.rdata = (ri == 5'd31) ? mdl : 32'h0;
      e.ccb   = mdl[ccpos(crs)];
      hit = we && (widx == 5'd31);
      nxt = mdl;
      if (hit) begin
        nxt[1:0]  = wd[1:0];
        nxt[6:2]  = wd[6:2];
        nxt[11:7] = wd[11:7];
        nxt[24]   = wd[24];
      end
      if (ov) begin
        nxt[16:12] = ex;
        nxt[6:2]   = nxt[6:2] | ex;
      end
      tr = (hit || ov) && ((nxt[16:12] & nxt[11:7]) != 5'b0);
      if (ov && cw && !tr) nxt[ccpos(cs)] = cv;
      e.trap = tr;
      e.wb   = ov && wbr && !tr;
      mdl = nxt;
    end
    e.rm = mdl[1:0];
    e.fl = mdl[24];
    sb_q.push_back(e);
  endtask

  task automatic idle(input string tag, input logic [4:0] ri, input logic [2:0] crs);
    cyc(tag, 0, 0, 5'd0, 32'h0, 0, 5'd0, 0, 0, 3'd0, 0, ri, crs);
  endtask

  task automatic swr(input string tag, input logic [4:0] widx, input logic [31:0] wd);
    cyc(tag, 0, 1, widx, wd, 0, 5'd0, 0, 0, 3'd0, 0, 5'd31, 3'd0);
  endtask

  task automatic opr(input string tag, input logic [4:0] ex, input logic wbr,
                     input logic cw, input logic [2:0] cs, input logic cv);
    cyc(tag, 0, 0, 5'd0, 32'h0, 1, ex, wbr, cw, cs, cv, 5'd31, 3'd0);
  endtask

  // Monitor: pops expected items and compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (sb_q.size() > 0) begin
        cur = sb_q.pop_front();
        chk(cur.tag, "trap",       32'(trap),       32'(cur.trap));
        chk(cur.tag, "wb_en",      32'(wb_en),      32'(cur.wb));
        chk(cur.tag, "sw_rdata",   sw_rdata,        cur.rdata);
        chk(cur.tag, "cc_rd_bit",  32'(cc_rd_bit),  32'(cur.ccb));
        chk(cur.tag, "round_mode", 32'(round_mode), 32'(cur.rm));
        chk(cur.tag, "flush_en",   32'(flush_en),   32'(cur.fl));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cyc("R1", 1, 0, 5'd0, 32'h0, 0, 5'd0, 0, 0, 3'd0, 0, 5'd31, 3'd0);
    cyc("R1", 1, 0, 5'd0, 32'h0, 0, 5'd0, 0, 0, 3'd0, 0, 5'd31, 3'd0);
    idle("R1", 5'd31, 3'd0);
    // R2: masked write, other index ignored
    swr("R2", 5'd31, 32'hFFFF_FFFF);
    idle("R2", 5'd31, 3'd0);
    // R3: index 0 and others read zero
    idle("R3", 5'd0, 3'd0);
    idle("R3", 5'd5, 3'd0);
    swr("R2", 5'd3, 32'h0);
    idle("R2", 5'd31, 3'd0);
    swr("R2", 5'd31, 32'h0);
    // R4/R5/R7: cause replaced, flags accumulate, write-back passes
    opr("R7", 5'b00101, 1, 0, 3'd0, 0);
    idle("R5", 5'd31, 3'd0);
    opr("R4", 5'b00010, 1, 0, 3'd0, 0);
    idle("R5", 5'd31, 3'd0);
    opr("R4", 5'b00000, 0, 0, 3'd0, 0);
    idle("R5", 5'd31, 3'd0);
    // R11: mode and flush outputs
    swr("R11", 5'd31, mk(1, 5'b01000, 5'b00000, 2'd3));
    idle("R11", 5'd31, 3'd0);
    // R6/R7/R9: enabled divide-by-zero traps, blocks write-back and cc write
    opr("R6", 5'b01000, 1, 1, 3'd3, 1);
    idle("R9", 5'd31, 3'd3);
    idle("R10", 5'd31, 3'd3);
    // R8: software write against a stale cause
    swr("R8", 5'd31, mk(1, 5'b00000, 5'b01000, 2'd3));
    swr("R8", 5'd31, mk(1, 5'b01000, 5'b01000, 2'd3));
    // R9/R10: condition code writes and reads
    opr("R9", 5'b00001, 1, 1, 3'd0, 1);
    opr("R9", 5'b00000, 0, 1, 3'd7, 1);
    idle("R10", 5'd31, 3'd0);
    idle("R10", 5'd31, 3'd7);
    idle("R10", 5'd31, 3'd3);
    opr("R9", 5'b00000, 0, 1, 3'd0, 0);
    idle("R10", 5'd31, 3'd0);
    // R12: collisions of software write and operation
    cyc("R12", 0, 1, 5'd31, mk(0, 5'b10000, 5'b00000, 2'd0),
        1, 5'b10010, 1, 1, 3'd2, 1, 5'd31, 3'd2);
    idle("R12", 5'd31, 3'd2);
    cyc("R12", 0, 1, 5'd31, mk(0, 5'b00000, 5'b00001, 2'd1),
        1, 5'b00100, 1, 0, 3'd0, 0, 5'd31, 3'd0);
    idle("R12", 5'd31, 3'd0);
    idle("R12", 5'd31, 3'd0);
    @(posedge clk);
    #5;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule